// File: doc/BRIEF.md
# Flash Block Lock-Bit Command Unit

This block is the lock-bit slice of a parallel NOR-flash command interface. Bus write cycles carry a command byte and a block index. A setup byte followed by a confirm byte either locks the single block named in the confirm write or unlocks every block at once. A short write-state-machine stand-in holds the unit busy for a fixed number of clocks while a change takes effect. Completion shows as ready on a status pin and on the top bit of an 8-bit status register. The error bits of that register report bad sequences, low program-voltage attempts and aborted clears.

The unit also acts as the gatekeeper for the array. A program or erase request to a block is granted only when the block is unlocked, the program voltage is valid, no lock operation is running and the lock state is known. If a clear is aborted because a supply leaves its valid range, the lock state is no longer trusted. The unit then treats every block as locked and raises an unknown flag until a later clear succeeds.

Top module: `flash_lock_cui`

## Requirements
- R1: Writing 0x60 and then 0x01 locks the block given on `wr_blk_i` during the confirm write. After `BUSY_CYCLES` busy clocks, that bit of `lock_o` reads 1 and no other bit changes.
- R2: Writing 0x60 and then 0xD0 clears every lock bit and `unknown_o` when the busy time ends. No other command or event ever turns a lock bit from 1 to 0.
- R3: From the clock edge that accepts a confirm, `sts_o` is 0 and status bit 7 is 0 for exactly `BUSY_CYCLES` clocks, then both return to 1. Every write made while busy, including setup, confirm and 0x50, is ignored.
- R4: A 0x60 written while `suspended_i` is high is rejected. It sets status bits 5 and 4, starts nothing, and the next write is decoded as a fresh command.
- R5: `rd_status_o` goes to 1 after a 0x60 or a 0x70 write and stays at 1 until a 0xFF write returns it to 0.
- R6: After a 0x60 setup, a confirm byte other than 0x01 or 0xD0 sets status bits 5 and 4. It leaves the lock bits unchanged and does not go busy.
- R7: A confirm while `vpen_ok_i` is low does not go busy and does not change the lock bits. For a clear it sets status bits 5 and 3; for a set it sets status bits 4 and 3.
- R8: A 0x50 write while idle clears status bits 5, 4 and 3.
- R9: If `vpen_ok_i` or `vcc_ok_i` is low during a clear's busy time, busy ends at the next edge. Status bit 5 is set, `unknown_o` goes to 1 and every lock bit reads 1. Only a later successful clear lowers `unknown_o`.
- R10: `pgm_grant_o` equals `pgm_req_i` AND NOT `lock_o[pgm_blk_i]` AND `vpen_ok_i` AND NOT busy AND NOT `unknown_o`.
- R11: The status register reads {ready, 0, bit5, bit4, bit3, 000}. After reset it reads 0x80, with all lock bits 0, `unknown_o` 0 and `rd_status_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe, one clock per write |
| wr_data_i | input | 8 | Command or confirm byte |
| wr_blk_i | input | BLK_W | Block field of the write address |
| vpen_ok_i | input | 1 | Program voltage valid |
| vcc_ok_i | input | 1 | Core supply valid |
| suspended_i | input | 1 | Array operation suspended |
| pgm_req_i | input | 1 | Program or erase request from the array side |
| pgm_blk_i | input | BLK_W | Block targeted by the request |
| pgm_grant_o | output | 1 | Request allowed |
| sts_o | output | 1 | Ready (1) or busy (0) |
| status_o | output | 8 | Status register |
| rd_status_o | output | 1 | Reads return status data |
| lock_o | output | NUM_BLOCKS | Lock bit per block |
| unknown_o | output | 1 | Lock state not trusted |

## Verification
A wrong decoder state shows on the next write. A confirm byte is taken as a command, or a command as a confirm, and the wrong bits appear in `status_o` or `lock_o` at the edge after that write. A wrong busy counter shows as `sts_o` rising a clock early or late, so the bench samples the ready pin on both sides of the expected edge. A lock or unknown bit that drifts shows at once on `lock_o`, `unknown_o` and `pgm_grant_o`, which random block probes compare against a bench model.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
  localparam logic [7:0] CFM_SET        = 8'h01;
  localparam logic [7:0] CFM_CLR        = 8'hD0;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_RD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;

  typedef enum logic {ST_IDLE, ST_SETUP} dec_state_e;
  typedef enum logic {OP_SET, OP_CLR} lock_op_e;
endpackage

// File: rtl/flk_cmd_dec.sv
module flk_cmd_dec
  import flk_pkg::*;
#(
  parameter int BLK_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [BLK_W-1:0] wr_blk_i,
  input  logic             busy_i,
  input  logic             suspended_i,
  input  logic             vpen_ok_i,
  output logic             go_set_o,
  output logic             go_clr_o,
  output logic [BLK_W-1:0] go_blk_o,
  output logic             err_seq_o,
  output logic             err_vset_o,
  output logic             err_vclr_o,
  output logic             clr_sr_o,
  output logic             rd_status_o
);
  dec_state_e state_q, state_d;
  logic       rdstat_q, rdstat_d;
  logic       acc;

  assign acc      = wr_en_i & ~busy_i;  // writes while busy are dropped
  assign go_blk_o = wr_blk_i;

  always_comb begin
    state_d    = state_q;
    rdstat_d   = rdstat_q;
    go_set_o   = 1'b0;
    go_clr_o   = 1'b0;
    err_seq_o  = 1'b0;
    err_vset_o = 1'b0;
    err_vclr_o = 1'b0;
    clr_sr_o   = 1'b0;
    if (acc) begin
      if (state_q == ST_IDLE) begin
        case (wr_data_i)
          CMD_LOCK_SETUP: begin
            rdstat_d = 1'b1;
            if (suspended_i) err_seq_o = 1'b1;
            else             state_d   = ST_SETUP;
          end
          CMD_RD_STATUS:  rdstat_d = 1'b1;
          CMD_RD_ARRAY:   rdstat_d = 1'b0;
          CMD_CLR_STATUS: clr_sr_o = 1'b1;
          default: ;
        endcase
      end else begin
        state_d = ST_IDLE;
        if (wr_data_i == CFM_SET) begin
          if (vpen_ok_i) go_set_o   = 1'b1;
          else           err_vset_o = 1'b1;
        end else if (wr_data_i == CFM_CLR) begin
          if (vpen_ok_i) go_clr_o   = 1'b1;
          else           err_vclr_o = 1'b1;
        end else begin
          err_seq_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rdstat_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rdstat_q <= rdstat_d;
    end
  end

  assign rd_status_o = rdstat_q;

  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !(go_set_o || go_clr_o || clr_sr_o)); // R3
  AST_SETUP_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP && wr_en_i && !busy_i) |=> (state_q == ST_IDLE)); // R6
endmodule

// File: rtl/flk_wsm.sv
module flk_wsm
  import flk_pkg::*;
#(
  parameter int BLK_W       = 3,
  parameter int BUSY_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_set_i,
  input  logic             go_clr_i,
  input  logic [BLK_W-1:0] go_blk_i,
  input  logic             err_seq_i,
  input  logic             err_vset_i,
  input  logic             err_vclr_i,
  input  logic             clr_sr_i,
  input  logic             vpen_ok_i,
  input  logic             vcc_ok_i,
  output logic             busy_o,
  output logic             set_done_o,
  output logic             clr_done_o,
  output logic             abort_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [7:0]       status_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  lock_op_e         op_q;
  logic [BLK_W-1:0] blk_q;
  logic             sr5_q, sr4_q, sr3_q;
  logic             last;

  assign last       = busy_q && (cnt_q == '0);
  assign abort_o    = busy_q && (op_q == OP_CLR) && (!vpen_ok_i || !vcc_ok_i);
  assign set_done_o = last && (op_q == OP_SET);
  assign clr_done_o = last && (op_q == OP_CLR) && !abort_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_SET;
      blk_q  <= '0;
    end else if (go_set_i || go_clr_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
      op_q   <= go_clr_i ? OP_CLR : OP_SET;
      blk_q  <= go_blk_i;
    end else if (busy_q) begin
      if (abort_o || last) busy_q <= 1'b0;
      else                 cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr5_q <= 1'b0;
      sr4_q <= 1'b0;
      sr3_q <= 1'b0;
    end else if (clr_sr_i) begin
      sr5_q <= 1'b0;
      sr4_q <= 1'b0;
      sr3_q <= 1'b0;
    end else begin
      if (err_seq_i || err_vclr_i || abort_o) sr5_q <= 1'b1;
      if (err_seq_i || err_vset_i)            sr4_q <= 1'b1;
      if (err_vset_i || err_vclr_i)           sr3_q <= 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign blk_o    = blk_q;
  assign status_o = {~busy_q, 1'b0, sr5_q, sr4_q, sr3_q, 3'b000};

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_set_i || go_clr_i) |=> busy_q); // R3
  AST_ERR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_sr_i |=> (status_o[5:3] == 3'b000)); // R8
  AST_ABORT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (!busy_q && status_o[5])); // R9
endmodule

// File: rtl/flk_lock_bank.sv
module flk_lock_bank #(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_done_i,
  input  logic                  clr_done_i,
  input  logic                  abort_i,
  input  logic [BLK_W-1:0]      blk_i,
  input  logic                  busy_i,
  input  logic                  vpen_ok_i,
  input  logic                  pgm_req_i,
  input  logic [BLK_W-1:0]      pgm_blk_i,
  output logic                  pgm_grant_o,
  output logic [NUM_BLOCKS-1:0] lock_o,
  output logic                  unknown_o
);
  logic [NUM_BLOCKS-1:0] lock_q;
  logic                  unk_q;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  lock_q[g] <= 1'b0;
      else if (abort_i)                             lock_q[g] <= 1'b1;  // untrusted: fail safe
      else if (clr_done_i)                          lock_q[g] <= 1'b0;
      else if (set_done_i && blk_i == BLK_W'(g))    lock_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         unk_q <= 1'b0;
    else if (abort_i)    unk_q <= 1'b1;
    else if (clr_done_i) unk_q <= 1'b0;
  end

  assign pgm_grant_o = pgm_req_i && !lock_q[pgm_blk_i] && vpen_ok_i && !busy_i && !unk_q;
  assign lock_o      = lock_q;
  assign unknown_o   = unk_q;

  AST_NO_STRAY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_done_i |=> ((lock_q & $past(lock_q)) == $past(lock_q))); // R2
  AST_SET_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_done_i && !abort_i) |=> ($countones(lock_q ^ $past(lock_q)) <= 1)); // R1
  AST_UNK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unk_q && !clr_done_i) |=> unk_q); // R9
endmodule

// File: rtl/flash_lock_cui.sv
module flash_lock_cui #(
  parameter int NUM_BLOCKS  = 8,
  parameter int BUSY_CYCLES = 8,
  localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_data_i,
  input  logic [BLK_W-1:0]      wr_blk_i,
  input  logic                  vpen_ok_i,
  input  logic                  vcc_ok_i,
  input  logic                  suspended_i,
  input  logic                  pgm_req_i,
  input  logic [BLK_W-1:0]      pgm_blk_i,
  output logic                  pgm_grant_o,
  output logic                  sts_o,
  output logic [7:0]            status_o,
  output logic                  rd_status_o,
  output logic [NUM_BLOCKS-1:0] lock_o,
  output logic                  unknown_o
);
  logic             busy, go_set, go_clr, err_seq, err_vset, err_vclr, clr_sr;
  logic             set_done, clr_done, abort;
  logic [BLK_W-1:0] go_blk, op_blk;

  flk_cmd_dec #(.BLK_W(BLK_W)) u_dec (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .wr_blk_i,
    .busy_i(busy), .suspended_i, .vpen_ok_i,
    .go_set_o(go_set), .go_clr_o(go_clr), .go_blk_o(go_blk),
    .err_seq_o(err_seq), .err_vset_o(err_vset), .err_vclr_o(err_vclr),
    .clr_sr_o(clr_sr), .rd_status_o
  );

  flk_wsm #(.BLK_W(BLK_W), .BUSY_CYCLES(BUSY_CYCLES)) u_wsm (
    .clk_i, .rst_ni, .go_set_i(go_set), .go_clr_i(go_clr), .go_blk_i(go_blk),
    .err_seq_i(err_seq), .err_vset_i(err_vset), .err_vclr_i(err_vclr),
    .clr_sr_i(clr_sr), .vpen_ok_i, .vcc_ok_i,
    .busy_o(busy), .set_done_o(set_done), .clr_done_o(clr_done),
    .abort_o(abort), .blk_o(op_blk), .status_o
  );

  flk_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_bank (
    .clk_i, .rst_ni, .set_done_i(set_done), .clr_done_i(clr_done),
    .abort_i(abort), .blk_i(op_blk), .busy_i(busy), .vpen_ok_i,
    .pgm_req_i, .pgm_blk_i, .pgm_grant_o, .lock_o, .unknown_o
  );

  assign sts_o = ~busy;

  AST_GRANT_NOT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_grant_o |-> (sts_o && !unknown_o)); // R10
endmodule

// File: tb/flash_lock_cui_tb_top.sv
module flash_lock_cui_tb_top;
  localparam int NB   = 8;
  localparam int BW   = 3;
  localparam int BUSY = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [BW-1:0] wr_blk = '0;
  logic          vpen_ok = 1'b1, vcc_ok = 1'b1, suspended = 1'b0;
  logic          pgm_req = 1'b0;
  logic [BW-1:0] pgm_blk = '0;
  logic          pgm_grant, sts, rd_status, unknown;
  logic [7:0]    status;
  logic [NB-1:0] lock;

  logic [NB-1:0] m_lock = '0;
  logic          m_unk = 1'b0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_lock_cui #(.NUM_BLOCKS(NB), .BUSY_CYCLES(BUSY)) dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_blk_i(wr_blk),
    .vpen_ok_i(vpen_ok), .vcc_ok_i(vcc_ok), .suspended_i(suspended),
    .pgm_req_i(pgm_req), .pgm_blk_i(pgm_blk), .pgm_grant_o(pgm_grant),
    .sts_o(sts), .status_o(status), .rd_status_o(rd_status),
    .lock_o(lock), .unknown_o(unknown)
  );

  function automatic logic [7:0] exp_sr(logic rdy, logic b5, logic b4, logic b3);
    return {rdy, 1'b0, b5, b4, b3, 3'b000};
  endfunction

  function automatic logic exp_grant(logic req, logic [NB-1:0] lk, logic [BW-1:0] b,
                                     logic vp, logic unk);
    return req && !lk[b] && vp && !unk;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d, logic [BW-1:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_blk = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    repeat (BUSY - 1) @(negedge clk);
    chk("R3 busy until last cycle", sts, 0);
    @(negedge clk);
    chk("R3 ready after busy", sts, 1);
  endtask

  task automatic do_set(logic [BW-1:0] b);
    wr(8'h60, 3'd0);
    wr(8'h01, b);
    chk("R3 busy at start", {sts, status[7]}, 0);
    wait_ready();
    m_lock[b] = 1'b1;
    chk("R1 lock bits after set", lock, m_lock);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 status reset", status, 8'h80);
    chk("R11 lock reset", lock, 0);
    chk("R11 flags reset", {sts, rd_status, unknown}, 3'b100);

    // R5 read mode
    wr(8'h70, 0);
    chk("R5 read status after 0x70", rd_status, 1);
    wr(8'hFF, 0);
    chk("R5 array after 0xFF", rd_status, 0);

    // R1 directed
    do_set(3'd3);
    chk("R5 read status after setup", rd_status, 1);
    chk("R11 status after set", status, 8'h80);

    // R3 writes during busy ignored
    wr(8'h60, 0);
    wr(8'h01, 3'd5);
    wr(8'h60, 0);
    wr(8'hD0, 0);
    repeat (BUSY - 2) @(negedge clk);
    m_lock[5] = 1'b1;
    chk("R3 ready after busy with ignored writes", sts, 1);
    chk("R3 ignored clear during busy", lock, m_lock);
    wr(8'h01, 3'd7);
    chk("R3 stray confirm in idle ignored", {sts, lock}, {1'b1, m_lock});

    // R1 random sets
    for (int i = 0; i < 12; i++) begin
      logic [BW-1:0] b;
      b = BW'($urandom % NB);
      do_set(b);
    end

    // R10 random probes
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      pgm_req = 1'($urandom);
      pgm_blk = BW'($urandom % NB);
      vpen_ok = ($urandom % 4) != 0;
      #1;
      chk("R10 grant", pgm_grant, exp_grant(pgm_req, m_lock, pgm_blk, vpen_ok, m_unk));
    end
    @(negedge clk);
    vpen_ok = 1'b1; pgm_req = 1'b0;

    // R6 bad confirm
    wr(8'h60, 0);
    wr(8'h33, 3'd1);
    chk("R6 bad confirm status", status, exp_sr(1, 1, 1, 0));
    chk("R6 locks unchanged", lock, m_lock);

    // R8
    wr(8'h50, 0);
    chk("R8 clear status", status, 8'h80);

    // R4 suspended
    suspended = 1'b1;
    wr(8'h60, 0);
    chk("R4 rejected setup status", status, exp_sr(1, 1, 1, 0));
    wr(8'hD0, 0);
    chk("R4 no clear after reject", {sts, lock}, {1'b1, m_lock});
    suspended = 1'b0;
    wr(8'h50, 0);

    // R7 low VPEN
    vpen_ok = 1'b0;
    wr(8'h60, 0);
    wr(8'hD0, 0);
    chk("R7 clear low vpen status", status, exp_sr(1, 1, 0, 1));
    chk("R7 clear low vpen locks", lock, m_lock);
    wr(8'h50, 0);
    wr(8'h60, 0);
    wr(8'h01, 3'd0);
    chk("R7 set low vpen status", status, exp_sr(1, 0, 1, 1));
    chk("R7 set low vpen locks", lock, m_lock);
    vpen_ok = 1'b1;
    wr(8'h50, 0);

    // R2 clear all
    wr(8'h60, 0);
    wr(8'hD0, 0);
    chk("R2 busy during clear", sts, 0);
    wait_ready();
    m_lock = '0;
    chk("R2 all cleared", lock, 0);

    // R9 abort
    do_set(3'd2);
    wr(8'h60, 0);
    wr(8'hD0, 0);
    @(negedge clk);
    vcc_ok = 1'b0;
    @(negedge clk);
    vcc_ok = 1'b1;
    m_lock = '1; m_unk = 1'b1;
    chk("R9 abort status", status, exp_sr(1, 1, 0, 0));
    chk("R9 abort locks", {unknown, lock}, {m_unk, m_lock});
    pgm_req = 1'b1; pgm_blk = 3'd4;
    #1;
    chk("R10 no grant when unknown", pgm_grant, 0);
    pgm_req = 1'b0;
    wr(8'h50, 0);
    wr(8'h60, 0);
    wr(8'hD0, 0);
    wait_ready();
    m_lock = '0; m_unk = 1'b0;
    chk("R9 successful clear removes unknown", {unknown, lock}, {m_unk, m_lock});
    pgm_req = 1'b1; pgm_blk = 3'd4;
    #1;
    chk("R10 grant restored", pgm_grant, 1);
    pgm_req = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule